// File: doc/BRIEF.md
# Program Counter with Two-Level Return Stack

This block is the instruction-address datapath of a small RISC core whose program space is 512 words. It keeps a 9-bit program counter and a return stack with two levels. The core's controller drives it once per instruction. It can advance the counter by one, jump to an absolute address, call a subroutine, or return from one. A call saves the address of the next instruction before it jumps. A return reloads the counter from the saved address.

The next counter value comes from one of four sources, chosen by a 2-bit select: the full jump field of the instruction, the call form of that field with its top bit cleared, the internal 8-bit ALU bus with a zero extension, or the top of the return stack. Separate strobes load the counter, increment it, move the stack up or down, and write the stack top. These strobes are independent, so the controller can combine them in one cycle. The top of the stack appears on an output at all times.

The stack depth is tracked by a three-state machine: `STK_EMPTY`, `STK_ONE` and `STK_FULL`. A push alone moves `STK_EMPTY`→`STK_ONE`→`STK_FULL`, and `STK_FULL` stays `STK_FULL` on a push. A pop alone moves `STK_FULL`→`STK_ONE`→`STK_EMPTY`, and `STK_EMPTY` stays `STK_EMPTY` on a pop. Every other strobe combination holds the state. The stack never reports an error, and it discards an entry only when a third push drops the oldest one.

Top module: `pc_return_stack`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `pc_q` is 0x1FF and `stack_top` is 0. The stack holds no entries at that point.
- R2: When `pc_load` is low, `pc_step` high makes `pc_q` one greater after the next rising edge, wrapping from 0x1FF to 0. When both are low, `pc_q` holds its value.
- R3: When `pc_load` is high, `pc_q` takes the selected source at the next rising edge, and `pc_step` is ignored. The `pc_sel` encodings are: 0 gives `jump_addr`; 1 gives `jump_addr` with bit 8 forced to 0; 2 gives `alu_bus` zero-extended to 9 bits; 3 gives `stack_top`.
- R4: `stk_we` writes `pc_q`+1 (modulo 512), as it was before the edge, into the stack top. When `sp_push` is also high without `sp_pop`, the previous top moves down one level first.
- R5: A pop (`sp_pop` high, `sp_push` low, `stk_we` low) when two entries are held makes `stack_top` show the older entry after the edge. A pop combined with `pc_sel`=3 and `pc_load` loads the newer entry into `pc_q` in the same cycle.
- R6: A push when two entries are held discards the oldest entry. Later pops then return the two most recent entries, newest first.
- R7: A pop when one entry or no entry is held leaves `stack_top` unchanged, so repeated returns keep yielding the last stored address.
- R8: `sp_push` and `sp_pop` high together change neither the level nor the stored entries. Only `stk_we` can still write the top in that case.
- R9: `stk_we` without a stack move overwrites the top in place and does not change the level. With no stack strobe, `stack_top` is stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_sel | input | 2 | Counter source: 0 jump, 1 call target, 2 ALU bus, 3 stack top |
| pc_load | input | 1 | Load the selected source into the counter |
| pc_step | input | 1 | Increment the counter (lower priority than `pc_load`) |
| sp_push | input | 1 | Move the stack one level deeper |
| sp_pop | input | 1 | Move the stack one level shallower |
| stk_we | input | 1 | Write the return address into the stack top |
| jump_addr | input | 9 | Target field of the current instruction |
| alu_bus | input | 8 | Internal ALU result bus |
| pc_q | output | 9 | Current program counter |
| stack_top | output | 9 | Current top of the return stack |

## Verification
If the depth state machine is in the wrong state, the error shows on `stack_top` only at a later pop. A pop either exposes an entry that should still be hidden, or fails to expose the older one. For this reason the stimulus runs long mixed sequences of pushes and pops, and it compares both outputs against an arithmetic model after every edge. A wrong slot write or a wrong source selection shows one edge later, on `stack_top` or `pc_q`.

// File: rtl/pc_stack_pkg.sv
package pc_stack_pkg;

    typedef enum logic [1:0] {
        SRC_JUMP  = 2'd0,
        SRC_CALL  = 2'd1,
        SRC_ALU   = 2'd2,
        SRC_STACK = 2'd3
    } pc_src_e;

    typedef enum logic [1:0] {
        STK_EMPTY = 2'd0,
        STK_ONE   = 2'd1,
        STK_FULL  = 2'd2
    } stk_level_e;

endpackage

// File: rtl/pc_src_mux.sv
module pc_src_mux
    import pc_stack_pkg::*;
#(
    parameter int PC_W  = 9,
    parameter int ALU_W = 8
) (
    input  logic [1:0]       sel,
    input  logic [PC_W-1:0]  jump_addr,
    input  logic [ALU_W-1:0] alu_bus,
    input  logic [PC_W-1:0]  stack_top,
    output logic [PC_W-1:0]  next_pc
);
    localparam int CALL_W = PC_W - 1;

    pc_src_e src;
    assign src = pc_src_e'(sel);

    always_comb begin
        unique case (src)
            SRC_JUMP:  next_pc = jump_addr;
            SRC_CALL:  next_pc = {1'b0, jump_addr[CALL_W-1:0]};
            SRC_ALU:   next_pc = PC_W'(alu_bus);
            SRC_STACK: next_pc = stack_top;
            default:   next_pc = jump_addr;
        endcase
    end
endmodule

// File: rtl/pc_register.sv
module pc_register #(
    parameter int              PC_W      = 9,
    parameter logic [PC_W-1:0] RESET_VEC = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic [PC_W-1:0] load_val,
    output logic [PC_W-1:0] pc,
    output logic [PC_W-1:0] pc_plus1
);
    assign pc_plus1 = pc + PC_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n)    pc <= RESET_VEC;
        else if (load) pc <= load_val;
        else if (step) pc <= pc_plus1;
    end
endmodule

// File: rtl/ret_stack.sv
module ret_stack
    import pc_stack_pkg::*;
#(
    parameter int PC_W = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic            pop,
    input  logic            we,
    input  logic [PC_W-1:0] wdata,
    output logic [PC_W-1:0] top
);
    stk_level_e      state_q, state_d;
    logic [PC_W-1:0] slot_top, slot_low;
    logic            up_only, down_only;
    logic            shift_down, shift_up;

    assign up_only   = push & ~pop;
    assign down_only = pop & ~push;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= STK_EMPTY;
        else        state_q <= state_d;
    end

    // next-state and slot-move decisions
    always_comb begin
        state_d    = state_q;
        shift_down = up_only;
        shift_up   = 1'b0;
        unique case (state_q)
            STK_EMPTY: if (up_only) state_d = STK_ONE;
            STK_ONE: begin
                if (up_only)        state_d = STK_FULL;
                else if (down_only) state_d = STK_EMPTY;
            end
            STK_FULL: begin
                if (down_only) begin
                    state_d  = STK_ONE;
                    shift_up = 1'b1;
                end
            end
            default: state_d = STK_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_top <= '0;
            slot_low <= '0;
        end else begin
            if (shift_down) slot_low <= slot_top;
            if (we)            slot_top <= wdata;
            else if (shift_up) slot_top <= slot_low;
        end
    end

    assign top = slot_top;
endmodule

// File: rtl/pc_return_stack.sv
module pc_return_stack #(
    parameter int              PC_W      = 9,
    parameter int              ALU_W     = 8,
    parameter logic [PC_W-1:0] RESET_VEC = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       pc_sel,
    input  logic             pc_load,
    input  logic             pc_step,
    input  logic             sp_push,
    input  logic             sp_pop,
    input  logic             stk_we,
    input  logic [PC_W-1:0]  jump_addr,
    input  logic [ALU_W-1:0] alu_bus,
    output logic [PC_W-1:0]  pc_q,
    output logic [PC_W-1:0]  stack_top
);
    logic [PC_W-1:0] next_pc;
    logic [PC_W-1:0] ret_addr;

    pc_src_mux #(.PC_W(PC_W), .ALU_W(ALU_W)) u_mux (
        .sel       (pc_sel),
        .jump_addr (jump_addr),
        .alu_bus   (alu_bus),
        .stack_top (stack_top),
        .next_pc   (next_pc)
    );

    pc_register #(.PC_W(PC_W), .RESET_VEC(RESET_VEC)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pc_load),
        .step     (pc_step),
        .load_val (next_pc),
        .pc       (pc_q),
        .pc_plus1 (ret_addr)
    );

    ret_stack #(.PC_W(PC_W)) u_stk (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (sp_push),
        .pop   (sp_pop),
        .we    (stk_we),
        .wdata (ret_addr),
        .top   (stack_top)
    );
endmodule

// File: rtl/pc_return_stack_chk.sv
module pc_return_stack_chk #(
    parameter int              PC_W      = 9,
    parameter logic [PC_W-1:0] RESET_VEC = '1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      pc_sel,
    input logic            pc_load,
    input logic            pc_step,
    input logic            sp_push,
    input logic            sp_pop,
    input logic            stk_we,
    input logic [PC_W-1:0] jump_addr,
    input logic [PC_W-1:0] pc_q,
    input logic [PC_W-1:0] stack_top
);
    // independent depth counter built from port activity
    logic [1:0] depth;
    always_ff @(posedge clk) begin
        if (!rst_n) depth <= 2'd0;
        else if (sp_push && !sp_pop && depth != 2'd2) depth <= depth + 2'd1;
        else if (sp_pop && !sp_push && depth != 2'd0) depth <= depth - 2'd1;
    end

    assert_reset_vector_R1: assert property (@(posedge clk)
        !rst_n |=> (pc_q == RESET_VEC && stack_top == '0));

    assert_pc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_load && !pc_step) |=> $stable(pc_q));

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_load && pc_step) |=> (pc_q == PC_W'($past(pc_q) + 1'b1)));

    assert_jump_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && pc_sel == 2'd0) |=> (pc_q == $past(jump_addr)));

    assert_return_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && pc_sel == 2'd3) |=> (pc_q == $past(stack_top)));

    assert_push_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stk_we |=> (stack_top == PC_W'($past(pc_q) + 1'b1)));

    assert_shallow_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_pop && !sp_push && !stk_we && depth != 2'd2) |=> $stable(stack_top));

    assert_push_pop_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_push && sp_pop && !stk_we) |=> $stable(stack_top));

    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sp_push && !sp_pop && !stk_we) |=> $stable(stack_top));
endmodule

bind pc_return_stack pc_return_stack_chk #(.PC_W(PC_W), .RESET_VEC(RESET_VEC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc_sel    (pc_sel),
    .pc_load   (pc_load),
    .pc_step   (pc_step),
    .sp_push   (sp_push),
    .sp_pop    (sp_pop),
    .stk_we    (stk_we),
    .jump_addr (jump_addr),
    .pc_q      (pc_q),
    .stack_top (stack_top)
);

// File: tb/test_pc_return_stack.sv
`timescale 1ns/1ps
module test_pc_return_stack;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] pc_sel;
    logic       pc_load, pc_step, sp_push, sp_pop, stk_we;
    logic [8:0] jump_addr;
    logic [7:0] alu_bus;
    logic [8:0] pc_q, stack_top;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model state
    logic [8:0] m_pc, m_top, m_low;
    int         m_lvl;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    pc_return_stack i_pc_return_stack (
        .clk(clk), .rst_n(rst_n), .pc_sel(pc_sel), .pc_load(pc_load),
        .pc_step(pc_step), .sp_push(sp_push), .sp_pop(sp_pop), .stk_we(stk_we),
        .jump_addr(jump_addr), .alu_bus(alu_bus), .pc_q(pc_q), .stack_top(stack_top)
    );

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] next_rand(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // one clock: drive, update model from requirements, check after edge
    task automatic step(input logic [1:0] sel, input logic ld, input logic inc,
                        input logic up, input logic dn, input logic we,
                        input logic [8:0] tgt, input logic [7:0] alu);
        logic [8:0] src_val, ret, n_pc, n_top, n_low;
        int         n_lvl;
        string      pc_req, top_req;
        pc_sel = sel; pc_load = ld; pc_step = inc; sp_push = up; sp_pop = dn;
        stk_we = we; jump_addr = tgt; alu_bus = alu;
        case (sel)
            2'd0: src_val = tgt;
            2'd1: src_val = {1'b0, tgt[7:0]};
            2'd2: src_val = {1'b0, alu};
            default: src_val = m_top;
        endcase
        ret   = m_pc + 9'd1;
        n_pc  = ld ? src_val : (inc ? m_pc + 9'd1 : m_pc);
        pc_req = ld ? "R3" : "R2";
        n_top = m_top; n_low = m_low; n_lvl = m_lvl;
        top_req = "R9";
        if (up && !dn) begin
            n_low = m_top;
            n_lvl = (m_lvl == 2) ? 2 : m_lvl + 1;
            top_req = (m_lvl == 2) ? "R6" : "R4";
        end else if (dn && !up) begin
            if (m_lvl == 2) begin n_top = m_low; top_req = "R5"; end
            else top_req = "R7";
            n_lvl = (m_lvl == 0) ? 0 : m_lvl - 1;
        end else if (up && dn) top_req = "R8";
        if (we) begin n_top = ret; top_req = "R4"; end
        @(posedge clk);
        m_pc = n_pc; m_top = n_top; m_low = n_low; m_lvl = n_lvl;
        @(negedge clk);
        chk(pc_req, pc_q, m_pc);
        chk(top_req, stack_top, m_top);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pc_sel = 2'd0; pc_load = 0; pc_step = 0;
        sp_push = 0; sp_pop = 0; stk_we = 0; jump_addr = '0; alu_bus = '0;
        repeat (3) @(negedge clk);
        chk("R1", pc_q, 9'h1FF);
        chk("R1", stack_top, 9'h000);
        rst_n = 1'b1;
        m_pc = 9'h1FF; m_top = '0; m_low = '0; m_lvl = 0;

        // R2: increment wraps from 0x1FF to 0
        step(2'd0, 0, 1, 0, 0, 0, 9'h000, 8'h00);
        chk("R2 wrap", pc_q, 9'h000);
        // R3: call target clears bit 8, pushes return address (R4)
        step(2'd0, 1, 0, 0, 0, 0, 9'h150, 8'h00);
        step(2'd1, 1, 1, 1, 0, 1, 9'h1AB, 8'h00);
        chk("R3 call", pc_q, 9'h0AB);
        chk("R4 push", stack_top, 9'h151);
        step(2'd1, 1, 0, 1, 0, 1, 9'h033, 8'h00);
        chk("R4 second", stack_top, 9'h0AC);
        // R6: third push drops oldest
        step(2'd1, 1, 0, 1, 0, 1, 9'h0F0, 8'h00);
        chk("R6 third", stack_top, 9'h034);
        // R5: return pops newest, exposes older
        step(2'd3, 1, 0, 0, 1, 0, 9'h000, 8'h00);
        chk("R5 ret pc", pc_q, 9'h034);
        chk("R5 ret top", stack_top, 9'h0AC);
        step(2'd3, 1, 0, 0, 1, 0, 9'h000, 8'h00);
        chk("R6 oldest dropped", pc_q, 9'h0AC);
        // R7: empty pop keeps last stored entry
        step(2'd3, 1, 0, 0, 1, 0, 9'h000, 8'h00);
        chk("R7 underflow", pc_q, 9'h0AC);
        // R3: ALU source zero-extended
        step(2'd2, 1, 1, 0, 0, 0, 9'h1FF, 8'hC7);
        chk("R3 alu", pc_q, 9'h0C7);
        // R8: push and pop together hold
        step(2'd0, 0, 0, 1, 1, 0, 9'h000, 8'h00);
        chk("R8 cancel", stack_top, 9'h0AC);

        // near-exhaustive sweep of every control combination, several passes
        for (int pass = 0; pass < 24; pass++) begin
            for (int c = 0; c < 128; c++) begin
                lfsr = next_rand(lfsr);
                step(c[1:0], c[2], c[3], c[4], c[5], c[6], lfsr[8:0], lfsr[15:8]);
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule